// File: doc/BRIEF.md
# Vector Single-Lane Access Decoder

This block takes one 32-bit vector load/store single-structure instruction word. It turns the word into a checked micro-operation descriptor for the memory pipeline behind it. The descriptor carries the register numbers, the direction, the post-index flag and the 64/128-bit width flag. It also gives the element scale and byte count, the number of consecutive vector registers involved (one to four), the lane to transfer, and whether the access loads one element and copies it to every lane. A base register of 31 names the stack pointer. In that case the descriptor asks for a stack-alignment check. Encodings whose scale, size and S bits form a reserved combination raise an undefined flag in place of a descriptor.

The decode is combinational. Its result is captured in a one-entry output stage. A two-state machine controls that stage. In EMPTY nothing is presented, and an accepted word causes the fill transition to FULL. In FULL the result is held until `op_ready`. At that point the stage either drains back to EMPTY or, if a new word arrives in the same cycle, takes the pass-through transition and stays FULL with the new result. The upstream side sees `ins_ready`, which is high whenever the stage is EMPTY or is being drained.

Top module: `sls_lane_decoder`

## Requirements
- R1: For a legal word, the presented descriptor carries these fields:
  - `op_vt` = bits [4:0]
  - `op_base` = bits [9:5]
  - `op_offset_reg` = bits [20:16]
  - `op_is_load` = bit 22
  - `op_post` = bit 23
  - `op_wide` = bit 30
- R2: `op_nregs` equals the two-bit value {bit 13, bit 21} plus one.
- R3: With scale field bits [15:14] = 0, the element is one byte (`op_scale`=0, `op_elem_bytes`=1) and `op_lane` = {bit30, bit12, bits[11:10]}.
- R4: With scale field 1, a word with bit 10 set is reserved. Otherwise `op_scale`=1, `op_elem_bytes`=2 and `op_lane` = {bit30, bit12, bit11}.
- R5: With scale field 2, a word with bit 11 set is reserved. With bits [11:10]=00, `op_scale`=2, `op_elem_bytes`=4 and `op_lane` = {bit30, bit12}.
- R6: With scale field 2 and bits [11:10]=01, a word with bit 12 set is reserved. Otherwise `op_scale`=3, `op_elem_bytes`=8 and `op_lane` = bit 30.
- R7: With scale field 3, a store (bit 22 = 0) or bit 12 = 1 is reserved. Otherwise `op_bcast`=1, `op_scale` = bits [11:10], `op_elem_bytes` = 1 << that value, and `op_lane`=0. `op_bcast` is 0 in every other case.
- R8: `op_sp_check` is 1 exactly when a valid descriptor has `op_base` = 31.
- R9: A reserved word presents `op_undef`=1 with `op_valid`=0, and every descriptor output reads 0.
- R10: An accepted word is presented in the next cycle. The result is held unchanged while `op_ready` is low. `ins_ready` = (stage EMPTY) or `op_ready`.
- R11: After reset, `op_valid` and `op_undef` are 0 and `ins_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction word offered |
| ins_ready | output | 1 | Decoder can take a word this cycle |
| ins_word | input | 32 | Instruction word |
| op_ready | input | 1 | Consumer accepts the presented result |
| op_valid | output | 1 | Legal descriptor presented |
| op_undef | output | 1 | Reserved encoding presented |
| op_vt | output | 5 | First vector register |
| op_base | output | 5 | Base address register |
| op_offset_reg | output | 5 | Post-index offset register field |
| op_is_load | output | 1 | Load (1) or store (0) |
| op_post | output | 1 | Post-index form |
| op_wide | output | 1 | 128-bit register form |
| op_bcast | output | 1 | Load and copy to all lanes |
| op_sp_check | output | 1 | Stack-alignment check request |
| op_scale | output | 2 | log2 of element bytes |
| op_elem_bytes | output | 4 | Element byte count |
| op_nregs | output | 3 | Consecutive registers, 1 to 4 |
| op_lane | output | 4 | Lane index |

## Verification
Directed words are applied first. They cover each scale class at its widest lane index, and each reserved size/S pattern next to its legal neighbour. This separates the shift amount chosen for each class and shows whether the reserved checks fire only on the bits they should. Base 31 is set against other base numbers to check the stack-check flag. Broadcast words are applied as loads and as stores, to check the direction gate. Long runs of random words with random offer and accept patterns then test the fill, drain, pass-through and hold transitions against a behavioural model of the stage.

// File: rtl/sls_pkg.sv
package sls_pkg;
    localparam int WORD_W   = 32;
    localparam int REG_W    = 5;
    localparam int LANE_W   = 4;
    localparam int SCALE_W  = 2;
    localparam int CNT_W    = 3;
    localparam int BYTES_W  = 4;
    localparam int SP_NUM   = (1 << REG_W) - 1;

    // bit positions the decoder depends on
    localparam int POS_RT   = 0;
    localparam int POS_RN   = 5;
    localparam int POS_SIZE = 10;
    localparam int POS_S    = 12;
    localparam int POS_OPC  = 13;
    localparam int POS_RM   = 16;
    localparam int POS_R    = 21;
    localparam int POS_LD   = 22;
    localparam int POS_POST = 23;
    localparam int POS_Q    = 30;

    typedef struct packed {
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] rn;
        logic [REG_W-1:0] rm;
        logic [1:0]       size;
        logic             s;
        logic [2:0]       opc;
        logic             r;
        logic             ld;
        logic             post;
        logic             q;
    } sls_fields_t;

    typedef struct packed {
        logic [REG_W-1:0]   vt;
        logic [REG_W-1:0]   base;
        logic [REG_W-1:0]   offs;
        logic               is_load;
        logic               post;
        logic               wide;
        logic               bcast;
        logic               sp_chk;
        logic [SCALE_W-1:0] scale;
        logic [CNT_W-1:0]   nregs;
        logic [LANE_W-1:0]  lane;
    } sls_desc_t;
endpackage

// File: rtl/sls_field_split.sv
module sls_field_split
    import sls_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output sls_fields_t       fld
);
    always_comb begin
        fld.rt   = word[POS_RT +: REG_W];
        fld.rn   = word[POS_RN +: REG_W];
        fld.rm   = word[POS_RM +: REG_W];
        fld.size = word[POS_SIZE +: 2];
        fld.s    = word[POS_S];
        fld.opc  = word[POS_OPC +: 3];
        fld.r    = word[POS_R];
        fld.ld   = word[POS_LD];
        fld.post = word[POS_POST];
        fld.q    = word[POS_Q];
    end
endmodule

// File: rtl/sls_lane_legalize.sv
module sls_lane_legalize
    import sls_pkg::*;
(
    input  sls_fields_t fld,
    output sls_desc_t   desc,
    output logic        undef
);
    logic [LANE_W-1:0]  raw_idx;
    logic [LANE_W-1:0]  lane;
    logic [SCALE_W-1:0] scale;
    logic               bcast;

    assign raw_idx = {fld.q, fld.s, fld.size};

    always_comb begin
        undef = 1'b0;
        scale = fld.opc[2:1];
        lane  = raw_idx;
        bcast = 1'b0;
        unique case (fld.opc[2:1])
            2'd0: ;
            2'd1: begin
                if (fld.size[0]) undef = 1'b1;
                else             lane  = raw_idx >> 1;
            end
            2'd2: begin
                if (fld.size[1])       undef = 1'b1;
                else if (!fld.size[0]) lane  = raw_idx >> 2;
                else if (fld.s)        undef = 1'b1;
                else begin
                    lane  = raw_idx >> 3;
                    scale = 2'd3;
                end
            end
            default: begin
                if (!fld.ld || fld.s) undef = 1'b1;
                else begin
                    bcast = 1'b1;
                    scale = fld.size;
                    lane  = '0;
                end
            end
        endcase
    end

    always_comb begin
        desc.vt      = fld.rt;
        desc.base    = fld.rn;
        desc.offs    = fld.rm;
        desc.is_load = fld.ld;
        desc.post    = fld.post;
        desc.wide    = fld.q;
        desc.bcast   = bcast;
        desc.sp_chk  = (fld.rn == REG_W'(SP_NUM));
        desc.scale   = scale;
        desc.nregs   = {1'b0, fld.opc[0], fld.r} + CNT_W'(1);
        desc.lane    = lane;
    end
endmodule

// File: rtl/sls_out_stage.sv
module sls_out_stage
    import sls_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    output logic      in_ready,
    input  sls_desc_t in_desc,
    input  logic      in_undef,
    input  logic      out_ready,
    output logic      out_full,
    output logic      out_undef,
    output sls_desc_t out_desc
);
    typedef enum logic {ST_EMPTY, ST_FULL} stage_st_t;
    stage_st_t st_q, st_d;
    logic      take;

    assign in_ready = (st_q == ST_EMPTY) || out_ready;
    assign take     = in_valid && in_ready;
    assign out_full = (st_q == ST_FULL);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: if (take) st_d = ST_FULL;
            ST_FULL:  if (out_ready && !take) st_d = ST_EMPTY;
            default:  st_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_undef <= 1'b0;
            out_desc  <= '0;
        end else if (take) begin
            out_undef <= in_undef;
            out_desc  <= in_undef ? '0 : in_desc;
        end else if (out_ready) begin
            out_undef <= 1'b0;
            out_desc  <= '0;
        end
    end
endmodule

// File: rtl/sls_lane_decoder.sv
module sls_lane_decoder
    import sls_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ins_valid,
    output logic                ins_ready,
    input  logic [WORD_W-1:0]   ins_word,
    input  logic                op_ready,
    output logic                op_valid,
    output logic                op_undef,
    output logic [REG_W-1:0]    op_vt,
    output logic [REG_W-1:0]    op_base,
    output logic [REG_W-1:0]    op_offset_reg,
    output logic                op_is_load,
    output logic                op_post,
    output logic                op_wide,
    output logic                op_bcast,
    output logic                op_sp_check,
    output logic [SCALE_W-1:0]  op_scale,
    output logic [BYTES_W-1:0]  op_elem_bytes,
    output logic [CNT_W-1:0]    op_nregs,
    output logic [LANE_W-1:0]   op_lane
);
    sls_fields_t fld;
    sls_desc_t   dec_desc;
    sls_desc_t   q_desc;
    logic        dec_undef;
    logic        q_full;
    logic        q_undef;

    sls_field_split u_split (.word(ins_word), .fld(fld));

    sls_lane_legalize u_legal (.fld(fld), .desc(dec_desc), .undef(dec_undef));

    sls_out_stage u_stage (
        .clk(clk), .rst_n(rst_n),
        .in_valid(ins_valid), .in_ready(ins_ready),
        .in_desc(dec_desc), .in_undef(dec_undef),
        .out_ready(op_ready), .out_full(q_full),
        .out_undef(q_undef), .out_desc(q_desc)
    );

    assign op_valid      = q_full && !q_undef;
    assign op_undef      = q_full && q_undef;
    assign op_vt         = q_desc.vt;
    assign op_base       = q_desc.base;
    assign op_offset_reg = q_desc.offs;
    assign op_is_load    = q_desc.is_load;
    assign op_post       = q_desc.post;
    assign op_wide       = q_desc.wide;
    assign op_bcast      = q_desc.bcast;
    assign op_sp_check   = q_desc.sp_chk;
    assign op_scale      = q_desc.scale;
    assign op_nregs      = q_desc.nregs;
    assign op_lane       = q_desc.lane;
    assign op_elem_bytes = op_valid ? (BYTES_W'(1) << q_desc.scale) : '0;
endmodule

// File: rtl/sls_lane_decoder_chk.sv
module sls_lane_decoder_chk
    import sls_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                ins_valid,
    input logic                ins_ready,
    input logic                op_ready,
    input logic                op_valid,
    input logic                op_undef,
    input logic [REG_W-1:0]    op_vt,
    input logic [REG_W-1:0]    op_base,
    input logic                op_is_load,
    input logic                op_bcast,
    input logic                op_sp_check,
    input logic [BYTES_W-1:0]  op_elem_bytes,
    input logic [CNT_W-1:0]    op_nregs,
    input logic [LANE_W-1:0]   op_lane
);
    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid || op_undef) && !op_ready |=>
        $stable({op_valid, op_undef, op_vt, op_base, op_lane, op_nregs, op_elem_bytes}));
    // R10
    accept_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && ins_ready |=> op_valid || op_undef);
    // R10
    empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid && !op_undef |-> ins_ready);
    // R9
    undef_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && op_undef));
    // R9
    undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_undef |-> op_nregs == '0 && op_elem_bytes == '0 && !op_sp_check && !op_bcast);
    // R8
    sp_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> op_sp_check == (op_base == REG_W'(SP_NUM)));
    // R7
    bcast_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_bcast |-> op_valid && op_is_load && op_lane == '0);
    // R2
    nregs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> op_nregs >= CNT_W'(1) && op_nregs <= CNT_W'(4));
    // R3
    bytes_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> $countones(op_elem_bytes) == 1);
endmodule

bind sls_lane_decoder sls_lane_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .op_ready(op_ready), .op_valid(op_valid), .op_undef(op_undef),
    .op_vt(op_vt), .op_base(op_base), .op_is_load(op_is_load),
    .op_bcast(op_bcast), .op_sp_check(op_sp_check),
    .op_elem_bytes(op_elem_bytes), .op_nregs(op_nregs), .op_lane(op_lane)
);

// File: tb/sls_lane_decoder_tb.sv
module sls_lane_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic        ins_ready;
    logic [31:0] ins_word = '0;
    logic        op_ready = 1'b0;
    logic        op_valid, op_undef, op_is_load, op_post, op_wide, op_bcast, op_sp_check;
    logic [4:0]  op_vt, op_base, op_offset_reg;
    logic [1:0]  op_scale;
    logic [3:0]  op_elem_bytes, op_lane;
    logic [2:0]  op_nregs;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference state
    bit m_full = 0, m_undef = 0;
    int m_vt, m_base, m_offs, m_ld, m_post, m_wide, m_bc, m_sp, m_scale, m_bytes, m_nr, m_lane;
    string m_tag = "R3";

    always #4 clk = ~clk;

    sls_lane_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_word(ins_word), .op_ready(op_ready), .op_valid(op_valid), .op_undef(op_undef),
        .op_vt(op_vt), .op_base(op_base), .op_offset_reg(op_offset_reg),
        .op_is_load(op_is_load), .op_post(op_post), .op_wide(op_wide),
        .op_bcast(op_bcast), .op_sp_check(op_sp_check), .op_scale(op_scale),
        .op_elem_bytes(op_elem_bytes), .op_nregs(op_nregs), .op_lane(op_lane)
    );

    function automatic logic [31:0] mk(int q, int ld, int post, int r, int rm, int opc,
                                       int s, int size, int rn, int rt);
        logic [31:0] w;
        w = 32'h0D00_0000;
        w = w | (32'(q & 1) << 30) | (32'(post & 1) << 23) | (32'(ld & 1) << 22)
              | (32'(r & 1) << 21) | (32'(rm & 31) << 16) | (32'(opc & 7) << 13)
              | (32'(s & 1) << 12) | (32'(size & 3) << 10) | (32'(rn & 31) << 5)
              | 32'(rt & 31);
        return w;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // behavioural decode of one word into the model registers
    task automatic ref_load(logic [31:0] w);
        int q, s, size, opc, raw, sc;
        bit bad;
        q = w[30]; s = w[12]; size = w[11:10]; opc = w[15:13];
        raw = q * 8 + s * 4 + size;
        sc = opc / 2; bad = 0;
        m_bc = 0;
        if (sc == 0) begin
            m_tag = "R3"; m_scale = 0; m_lane = raw;
        end else if (sc == 1) begin
            m_tag = "R4"; m_scale = 1; m_lane = raw / 2; bad = (size % 2) == 1;
        end else if (sc == 2 && size < 2 && size == 0) begin
            m_tag = "R5"; m_scale = 2; m_lane = raw / 4;
        end else if (sc == 2 && size >= 2) begin
            m_tag = "R5"; bad = 1;
        end else if (sc == 2) begin
            m_tag = "R6"; m_scale = 3; m_lane = q; bad = (s == 1);
        end else begin
            m_tag = "R7"; m_scale = size; m_lane = 0; m_bc = 1;
            bad = (w[22] == 0) || (s == 1);
        end
        m_undef = bad;
        if (bad) begin
            m_vt = 0; m_base = 0; m_offs = 0; m_ld = 0; m_post = 0; m_wide = 0;
            m_bc = 0; m_sp = 0; m_scale = 0; m_bytes = 0; m_nr = 0; m_lane = 0;
        end else begin
            m_vt = w[4:0]; m_base = w[9:5]; m_offs = w[20:16];
            m_ld = w[22]; m_post = w[23]; m_wide = q;
            m_sp = (m_base == 31);
            m_bytes = 1 << m_scale;
            m_nr = (opc % 2) * 2 + w[21] + 1;
        end
    endtask

    task automatic compare();
        string ft;
        ft = m_full && m_undef ? "R9" : "R1";
        chk("R10 ins_ready", ins_ready, (!m_full || op_ready) ? 1 : 0);
        chk("R10 op_valid", op_valid, (m_full && !m_undef) ? 1 : 0);
        chk("R9 op_undef", op_undef, (m_full && m_undef) ? 1 : 0);
        if (m_full) begin
            chk({ft, " vt"}, op_vt, m_vt);
            chk({ft, " base"}, op_base, m_base);
            chk({ft, " offset"}, op_offset_reg, m_offs);
            chk({ft, " load"}, op_is_load, m_ld);
            chk({ft, " post"}, op_post, m_post);
            chk({ft, " wide"}, op_wide, m_wide);
            chk(m_undef ? "R9 nregs" : "R2 nregs", op_nregs, m_nr);
            chk(m_undef ? "R9 sp" : "R8 sp", op_sp_check, m_sp);
            chk(m_undef ? "R9 bcast" : "R7 bcast", op_bcast, m_bc);
            chk(m_undef ? "R9 scale" : {m_tag, " scale"}, op_scale, m_scale);
            chk(m_undef ? "R9 bytes" : {m_tag, " bytes"}, op_elem_bytes, m_bytes);
            chk(m_undef ? "R9 lane" : {m_tag, " lane"}, op_lane, m_lane);
        end
    endtask

    // one cycle: drive, model the edge, compare at the falling edge
    task automatic step(bit v, logic [31:0] w, bit rdy);
        bit m_rdy;
        ins_valid = v; ins_word = w; op_ready = rdy;
        m_rdy = !m_full || rdy;
        @(posedge clk);
        if (v && m_rdy) begin
            ref_load(w);
            m_full = 1;
        end else if (m_full && rdy) begin
            m_full = 0;
        end
        @(negedge clk);
        compare();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 op_valid", op_valid, 0);
        chk("R11 op_undef", op_undef, 0);
        chk("R11 ins_ready", ins_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 widest byte lane
        step(1, mk(1, 1, 0, 0, 0, 0, 1, 3, 4, 7), 1);
        // R4 legal and reserved
        step(1, mk(1, 0, 1, 1, 9, 2, 1, 2, 3, 2), 1);
        step(1, mk(1, 1, 0, 0, 0, 2, 1, 1, 3, 2), 1);
        // R5 legal and reserved
        step(1, mk(1, 1, 0, 1, 0, 4, 1, 0, 5, 6), 1);
        step(1, mk(0, 1, 0, 0, 0, 4, 0, 2, 5, 6), 1);
        // R6 legal and reserved
        step(1, mk(1, 0, 1, 0, 31, 5, 0, 1, 8, 1), 1);
        step(1, mk(1, 1, 0, 0, 0, 4, 1, 1, 8, 1), 1);
        // R7 broadcast load, store reserved, S reserved
        step(1, mk(0, 1, 0, 1, 0, 7, 0, 2, 31, 30), 1);
        step(1, mk(1, 1, 1, 0, 4, 6, 0, 3, 2, 0), 1);
        step(1, mk(1, 0, 0, 0, 0, 6, 0, 1, 2, 0), 1);
        step(1, mk(1, 1, 0, 0, 0, 6, 1, 1, 2, 0), 1);
        // R8 stack pointer base on a plain form
        step(1, mk(0, 0, 0, 1, 0, 1, 0, 0, 31, 3), 1);
        step(0, 0, 1);
        // R10 back-pressure: hold, then pass-through, then drain
        step(1, mk(1, 1, 0, 0, 0, 0, 0, 1, 1, 1), 0);
        step(1, mk(0, 1, 0, 0, 0, 2, 0, 0, 2, 2), 0);
        step(1, mk(0, 1, 0, 0, 0, 2, 0, 0, 2, 2), 0);
        step(1, mk(1, 0, 0, 0, 0, 2, 0, 1, 2, 2), 1);
        step(0, 0, 1);
        // random words and handshakes
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w;
            w = $urandom;
            w[31] = 1'b0;
            w[29:24] = 6'b001101;
            step(($urandom % 4) != 0, w, ($urandom % 3) != 0);
        end
        step(0, 0, 1);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule